// File: doc/BRIEF.md
# Debug communications channel mailbox

A two-way, one-word mailbox that links a debug host with an embedded processor. Each direction has one 32-bit data word and one full flag. The host sees a small register file with two addresses. The data address writes the outbound word and pops the inbound word. The control address is read-only. It returns both full flags, a sticky overflow bit and a fixed version code in its top nibble. Reading the data address is destructive: it clears the inbound full flag. A host that polls should therefore keep pointing at the control address, and read the data address only once per word.

The target side is a pair of valid/ready streams plus a status output.

- **Inbound stream (target reads):** `tgt_rd_valid` mirrors the host-to-target full flag. A beat with `tgt_rd_ready` high consumes the word.
- **Outbound stream (target writes):** `tgt_wr_ready` is high whenever the target-to-host word is empty, and a beat with `tgt_wr_valid` high loads it.
- **No back-pressure holding:** a write offered while `tgt_wr_ready` is low is not held. It is dropped and marks overflow, and the same rule applies to host writes. Producers are expected to poll the flag first.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both full flags, both data words, the overflow bit and `host_rdata` are zero; `tgt_rd_valid` is 0 and `tgt_wr_ready` is 1.
- R2: A host write to the data address (5) while the host-to-target flag (control bit 0) is clear stores the word and sets that flag; `tgt_rd_valid` goes high with `tgt_rd_data` equal to the word.
- R3: A target read beat (`tgt_rd_valid` and `tgt_rd_ready` both high) clears control bit 0.
- R4: A target write beat (`tgt_wr_valid` with `tgt_wr_ready` high) stores the word and sets the target-to-host flag (control bit 1); `tgt_wr_ready` then drops.
- R5: A host read of the data address returns the target-to-host word and clears control bit 1. A later read of that address changes nothing, and bit 1 stays 0 until the target writes again.
- R6: A write in either direction while that direction's flag is already set is dropped, and the stored word is kept. The write also sets the overflow bit (control bit 2), which stays set until reset.
- R7: A control read (address 4) returns the VERSION parameter (default 6) in bits 31:28 and zero in bits 27:3.
- R8: A host write to the control address or to any unmapped address changes no state. A read of an unmapped address returns zero.
- R9: Host read data appears on `host_rdata` one cycle after the request and holds until the next host read.
- R10: When a consume and a new write hit a full slot in the same cycle, the consume wins and the write is dropped with overflow, leaving the slot empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Register address (4 control, 5 data) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after request |
| tgt_rd_valid | output | 1 | Host-to-target word present |
| tgt_rd_ready | input | 1 | Target consumes the word |
| tgt_rd_data | output | 32 | Host-to-target word |
| tgt_wr_valid | input | 1 | Target offers a word |
| tgt_wr_ready | output | 1 | Target-to-host slot empty |
| tgt_wr_data | input | 32 | Target write data |
| tgt_status | output | 3 | {overflow, target-to-host full, host-to-target full} |

## Verification
The main function is tried with alternating one-way transfers in each direction, which separates the two flags and shows that neither leaks into the other. Both slots are then filled at once, which shows that the control word reports both bits together and that each data word keeps its own contents. Back-to-back writes to a full slot separate dropping from overwriting. They also show that overflow is sticky. A same-cycle consume and write shows that the consume takes priority. Repeated data reads and writes to the control address and to unmapped addresses show that only the first destructive read clears a flag, and that the ignored accesses leave the state unchanged.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
  localparam int CTRL_BIT_H2T = 0;
  localparam int CTRL_BIT_T2H = 1;
  localparam int CTRL_BIT_OVF = 2;
  localparam int CTRL_FLAG_N  = 3;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] data,
  output logic         drop
);
  // A push is taken only into an empty slot; a pop only empties a full one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (pop && full) full <= 1'b0;
      if (push && !full) begin
        full <= 1'b1;
        data <= push_data;
      end
    end
  end

  assign drop = push && full;

  // R2
  push_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (full && data == $past(push_data)));

  // R3
  pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && full) |=> !full);

  // R6
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(data));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(full));
endmodule

// File: rtl/host_regif.sv
module host_regif #(
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] ctrl_word,
  input  logic [DW-1:0] t2h_word,
  output logic          h2t_push,
  output logic          t2h_pop,
  output logic [DW-1:0] host_rdata
);
  logic hit_ctrl, hit_data, rd_req;
  logic [DW-1:0] rd_mux;

  assign hit_ctrl = (host_addr == AW'(CTRL_ADDR));
  assign hit_data = (host_addr == AW'(DATA_ADDR));
  assign rd_req   = host_req && !host_we;
  assign h2t_push = host_req && host_we && hit_data;
  assign t2h_pop  = rd_req && hit_data;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux = ctrl_word;
    else if (hit_data) rd_mux = t2h_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      host_rdata <= '0;
    else if (rd_req) host_rdata <= rd_mux;
  end

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(host_rdata));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !hit_ctrl && !hit_data) |=> (host_rdata == '0));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 5,
  parameter int          VER_W     = 4,
  parameter logic [3:0]  VERSION   = 4'd6,
  parameter int          CTRL_ADDR = 4,
  parameter int          DATA_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              tgt_rd_valid,
  input  logic              tgt_rd_ready,
  output logic [DATA_W-1:0] tgt_rd_data,
  input  logic              tgt_wr_valid,
  output logic              tgt_wr_ready,
  input  logic [DATA_W-1:0] tgt_wr_data,
  output logic [2:0]        tgt_status
);
  import dbg_mailbox_pkg::*;

  localparam int VER_LSB = DATA_W - VER_W;

  logic h2t_push, h2t_full, h2t_drop;
  logic t2h_pop, t2h_full, t2h_drop;
  logic [DATA_W-1:0] h2t_word, t2h_word, ctrl_word;
  logic ovf_q;

  mbox_slot #(.W(DATA_W)) i_h2t (
    .clk(clk), .rst_n(rst_n), .push(h2t_push), .push_data(host_wdata),
    .pop(tgt_rd_ready), .full(h2t_full), .data(h2t_word), .drop(h2t_drop));

  mbox_slot #(.W(DATA_W)) i_t2h (
    .clk(clk), .rst_n(rst_n), .push(tgt_wr_valid), .push_data(tgt_wr_data),
    .pop(t2h_pop), .full(t2h_full), .data(t2h_word), .drop(t2h_drop));

  always_ff @(posedge clk) begin
    if (!rst_n)                     ovf_q <= 1'b0;
    else if (h2t_drop || t2h_drop)  ovf_q <= 1'b1;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_BIT_H2T] = h2t_full;
    ctrl_word[CTRL_BIT_T2H] = t2h_full;
    ctrl_word[CTRL_BIT_OVF] = ovf_q;
    ctrl_word[VER_LSB +: VER_W] = VERSION[VER_W-1:0];
  end

  host_regif #(.DW(DATA_W), .AW(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
               .DATA_ADDR(DATA_ADDR)) i_regif (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .ctrl_word(ctrl_word), .t2h_word(t2h_word),
    .h2t_push(h2t_push), .t2h_pop(t2h_pop), .host_rdata(host_rdata));

  assign tgt_rd_valid = h2t_full;
  assign tgt_rd_data  = h2t_word;
  assign tgt_wr_ready = !t2h_full;
  assign tgt_status   = {ovf_q, t2h_full, h2t_full};

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R7
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && host_addr == ADDR_W'(CTRL_ADDR)) |=>
      (host_rdata[VER_LSB +: VER_W] == VERSION[VER_W-1:0]));

  // R10
  consume_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h2t_full && tgt_rd_ready && h2t_push) |=> (!tgt_rd_valid && ovf_q));
endmodule

// File: tb/test_dbg_mailbox.sv
module test_dbg_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [4:0] host_addr = '0;
  logic [31:0] host_wdata = '0, tgt_wr_data = '0;
  logic [31:0] host_rdata, tgt_rd_data;
  logic tgt_rd_valid, tgt_wr_ready;
  logic tgt_rd_ready = 1'b0, tgt_wr_valid = 1'b0;
  logic [2:0] tgt_status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_mailbox i_dbg_mailbox (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tgt_rd_valid(tgt_rd_valid), .tgt_rd_ready(tgt_rd_ready),
    .tgt_rd_data(tgt_rd_data), .tgt_wr_valid(tgt_wr_valid),
    .tgt_wr_ready(tgt_wr_ready), .tgt_wr_data(tgt_wr_data),
    .tgt_status(tgt_status));

  localparam logic [2:0] HW = 3'd0, HR = 3'd1, TW = 3'd2, TR = 3'd3;
  localparam logic [31:0] CB = 32'h6000_0000;
  localparam int NV = 18;
  localparam logic [71:0] VEC [NV] = '{
    {HR, 5'd4, 32'h0,          CB},            // R7
    {HW, 5'd5, 32'hA5A5_0001,  32'h0},         // R2
    {HR, 5'd4, 32'h0,          CB | 32'h1},    // R2
    {TR, 5'd0, 32'h0,          32'hA5A5_0001}, // R2
    {HR, 5'd4, 32'h0,          CB},            // R3
    {TW, 5'd0, 32'h1234_5678,  32'h0},         // R4
    {HR, 5'd4, 32'h0,          CB | 32'h2},    // R4
    {HR, 5'd5, 32'h0,          32'h1234_5678}, // R5
    {HR, 5'd4, 32'h0,          CB},            // R5
    {HW, 5'd4, 32'hFFFF_FFFF,  32'h0},         // R8
    {HR, 5'd4, 32'h0,          CB},            // R8
    {HR, 5'd7, 32'h0,          32'h0},         // R8
    {TW, 5'd0, 32'hDEAD_BEEF,  32'h0},         // R4
    {HW, 5'd5, 32'h0BAD_F00D,  32'h0},         // R2
    {HR, 5'd4, 32'h0,          CB | 32'h3},    // R2 R4
    {HR, 5'd5, 32'h0,          32'hDEAD_BEEF}, // R5
    {TR, 5'd0, 32'h0,          32'h0BAD_F00D}, // R3
    {HR, 5'd4, 32'h0,          CB}             // R3 R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with results settled.
  task automatic op(input logic [2:0] kind, input logic [4:0] a, input logic [31:0] d);
    host_req = (kind == HW || kind == HR);
    host_we = (kind == HW);
    host_addr = a;
    host_wdata = d;
    tgt_wr_valid = (kind == TW);
    tgt_wr_data = d;
    tgt_rd_ready = (kind == TR);
    @(negedge clk);
    host_req = 0; host_we = 0; tgt_wr_valid = 0; tgt_rd_ready = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 host_rdata", host_rdata, 32'h0);
    check("R1 tgt_rd_valid", {31'h0, tgt_rd_valid}, 32'h0);
    check("R1 tgt_wr_ready", {31'h0, tgt_wr_ready}, 32'h1);
    check("R1 status", {29'h0, tgt_status}, 32'h0);
    check("R1 rd_data", tgt_rd_data, 32'h0);
    op(HR, 5'd5, 0);
    check("R1 t2h word", host_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] k;
      logic [4:0] a;
      logic [31:0] d, e;
      {k, a, d, e} = VEC[i];
      if (k == TR) begin
        check($sformatf("R2 vec%0d rd_valid", i), {31'h0, tgt_rd_valid}, 32'h1);
        check($sformatf("R2 vec%0d rd_data", i), tgt_rd_data, e);
      end
      op(k, a, d);
      if (k == HR) check($sformatf("R5/R7 vec%0d rdata", i), host_rdata, e);
    end

    // R5 second data read after pop: flag stays clear
    op(HR, 5'd5, 0);
    op(HR, 5'd4, 0);
    check("R5 stale read keeps W clear", host_rdata, CB);

    // R9 read data holds with no request
    repeat (3) @(negedge clk);
    check("R9 rdata holds", host_rdata, CB);
    op(HW, 5'd9, 32'h5555_5555);
    check("R9 rdata holds over write", host_rdata, CB);
    op(HR, 5'd4, 0);
    check("R8 unmapped write ignored", host_rdata, CB);

    // R6 target-side overflow
    op(TW, 0, 32'h1111_1111);
    check("R4 wr_ready low when full", {31'h0, tgt_wr_ready}, 32'h0);
    op(TW, 0, 32'h2222_2222);
    op(HR, 5'd4, 0);
    check("R6 ctrl after t2h overflow", host_rdata, CB | 32'h6);
    op(HR, 5'd5, 0);
    check("R6 t2h word kept", host_rdata, 32'h1111_1111);
    op(HR, 5'd4, 0);
    check("R6 overflow sticky", host_rdata, CB | 32'h4);

    // R6 host-side overflow
    op(HW, 5'd5, 32'h3333_3333);
    op(HW, 5'd5, 32'h4444_4444);
    check("R6 h2t word kept", tgt_rd_data, 32'h3333_3333);

    // R10 consume and write same cycle on full slot
    host_req = 1; host_we = 1; host_addr = 5'd5; host_wdata = 32'h7777_7777;
    tgt_rd_ready = 1;
    @(negedge clk);
    host_req = 0; host_we = 0; tgt_rd_ready = 0;
    check("R10 slot empty after race", {31'h0, tgt_rd_valid}, 32'h0);
    check("R10 word not replaced", tgt_rd_data, 32'h3333_3333);
    check("R10 overflow set", {29'h0, tgt_status}, 32'h4);

    // R1 R6 reset clears overflow
    do_reset();
    check("R1 overflow cleared", {29'h0, tgt_status}, 32'h0);
    check("R1 h2t word cleared", tgt_rd_data, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule